// File: doc/BRIEF.md
# Level-1 Trigger Fast Control Receiver

This block sits at the timing input of a readout board. It takes the level-1 accept line from the central trigger system and turns each accept pulse into a single trigger event, even though the pulse is held for several clock cycles. For each event it advances a running trigger number and stores a coarse timestamp taken from a free-running cycle counter. Downstream logic uses the timestamp to find the buffered detector data that belongs to the trigger.

The central system also sends a synchronisation check strobe after every 2^CHK_LOG2 triggers. The block keeps track of whether a check is owed. It raises a sticky error when a check arrives that was not owed, or when a new trigger arrives while a check is still owed. A second sticky flag marks accept pulses whose length differs from the nominal PULSE_LEN cycles. Such pulses are still counted once. Finally, the block drives the buffer-full flag back to the central system from the downstream occupancy, using two marks to give hysteresis.

Top module: `fc_trig_rx`

## Requirements
- R1: After reset, trig_evt, trig_num, trig_ts, sync_err, malformed_err and full_out are all zero.
- R2: Each accept pulse gives exactly one trig_evt. trig_evt is one cycle wide and is high in the cycle after the clock edge that first samples l1_in high. In that same cycle trig_num has grown by exactly one. A pulse held for many cycles is counted once.
- R3: trig_ts holds the value of a TS_W-bit cycle counter. The counter counts the clock edges since reset was released. The value stored is the count before the edge that first samples the accept pulse high.
- R4: An accept pulse that is high for fewer or more than PULSE_LEN (default 8) cycles sets malformed_err. A long pulse sets the flag once its (PULSE_LEN+1)-th high cycle is sampled. A short pulse sets it at the edge that samples the pulse low. The pulse is still counted once. A pulse of exactly PULSE_LEN cycles leaves the flag clear.
- R5: When a trigger brings trig_num to a multiple of 2^CHK_LOG2 (default 256), a check is owed. A check rising edge that arrives while a check is owed, or in the same cycle as that trigger, clears the debt and does not set sync_err.
- R6: A check rising edge that arrives when no check is owed sets sync_err. This includes a check with trig_num at zero or at any count that is not a multiple of 2^CHK_LOG2.
- R7: A trigger that arrives while a check is still owed, with no check in the same cycle, sets sync_err. That trigger is still counted.
- R8: full_out rises at the edge where occ_in is sampled at or above hi_mark.
- R9: full_out falls only at an edge where occ_in is sampled below lo_mark. When occ_in lies between the two marks, full_out keeps its previous value.
- R10: sync_err and malformed_err stay set through later correct traffic and are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_in | input | 1 | Level-1 accept line, held high for several cycles per trigger |
| chk_in | input | 1 | Synchronisation check strobe |
| occ_in | input | OCC_W | Downstream event buffer occupancy |
| hi_mark | input | OCC_W | Occupancy at which full_out asserts |
| lo_mark | input | OCC_W | Occupancy below which full_out deasserts |
| trig_evt | output | 1 | One-cycle event strobe per accept pulse |
| trig_num | output | NUM_W | Running trigger number |
| trig_ts | output | TS_W | Coarse timestamp of the latest trigger |
| sync_err | output | 1 | Sticky check/count mismatch flag |
| malformed_err | output | 1 | Sticky wrong-length pulse flag |
| full_out | output | 1 | Buffer-full flag to the central trigger system |

## Verification
The hardest situation to reach from the ports is the check boundary. It takes 256 complete accept pulses before a check is owed. The stimulus therefore drives full 8-cycle pulses in a loop until the count reaches the boundary. It then either sends the check, which must leave sync_err clear, or withholds it and sends a 257th trigger, which must set sync_err and still be counted. A separate run sends a check at a count of a few triggers to reach the unowed case.

// File: rtl/fc_trig_rx.sv
module fc_trig_rx #(
  parameter int NUM_W     = 32,
  parameter int TS_W      = 16,
  parameter int PULSE_LEN = 8,
  parameter int CHK_LOG2  = 8,
  parameter int OCC_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             l1_in,
  input  logic             chk_in,
  input  logic [OCC_W-1:0] occ_in,
  input  logic [OCC_W-1:0] hi_mark,
  input  logic [OCC_W-1:0] lo_mark,
  output logic             trig_evt,
  output logic [NUM_W-1:0] trig_num,
  output logic [TS_W-1:0]  trig_ts,
  output logic             sync_err,
  output logic             malformed_err,
  output logic             full_out
);
  localparam int LEN_W = $clog2(PULSE_LEN + 2);

  logic             l1_q, chk_q, owe;
  logic [LEN_W-1:0] len_cnt;
  logic [TS_W-1:0]  ts_cnt;

  wire             l1_rise   = l1_in & ~l1_q;
  wire             l1_fall   = ~l1_in & l1_q;
  wire             chk_rise  = chk_in & ~chk_q;
  wire [NUM_W-1:0] num_nxt   = trig_num + NUM_W'(l1_rise);
  wire             at_bound  = l1_rise && (num_nxt[CHK_LOG2-1:0] == '0);
  wire             too_long  = l1_in & l1_q & (len_cnt == LEN_W'(PULSE_LEN));
  wire             too_short = l1_fall & (len_cnt < LEN_W'(PULSE_LEN));
  wire             chk_bad   = chk_rise & ~(owe | at_bound);
  wire             chk_miss  = l1_rise & owe & ~chk_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l1_q          <= 1'b0;
      chk_q         <= 1'b0;
      owe           <= 1'b0;
      len_cnt       <= '0;
      ts_cnt        <= '0;
      trig_evt      <= 1'b0;
      trig_num      <= '0;
      trig_ts       <= '0;
      sync_err      <= 1'b0;
      malformed_err <= 1'b0;
      full_out      <= 1'b0;
    end else begin
      l1_q     <= l1_in;
      chk_q    <= chk_in;
      ts_cnt   <= ts_cnt + 1'b1;
      trig_evt <= l1_rise;
      if (l1_rise) begin
        trig_num <= num_nxt;
        trig_ts  <= ts_cnt;
        len_cnt  <= LEN_W'(1);
      end else if (l1_in && len_cnt != '1) begin
        len_cnt <= len_cnt + 1'b1;
      end
      owe <= chk_rise ? 1'b0 : (owe | at_bound);
      if (chk_bad | chk_miss) sync_err <= 1'b1;
      if (too_long | too_short) malformed_err <= 1'b1;
      if (occ_in >= hi_mark)     full_out <= 1'b1;
      else if (occ_in < lo_mark) full_out <= 1'b0;
    end
  end

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> !trig_evt);
  a_r2_num_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_evt |-> $stable(trig_num));
  a_r2_evt_follows_l1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |-> $past(l1_in));
  a_r10_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_err) |-> sync_err);
  a_r10_malformed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(malformed_err) |-> malformed_err);
  a_r8_full_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_out) |-> $past(occ_in >= hi_mark));
  a_r9_full_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_out) |-> $past(occ_in < lo_mark));
endmodule

// File: tb/sim_fc_trig_rx.sv
module sim_fc_trig_rx;
  localparam int TS_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l1_in = 1'b0, chk_in = 1'b0;
  logic [9:0]  occ_in = '0, hi_mark = 10'd10, lo_mark = 10'd4;
  logic        trig_evt, sync_err, malformed_err, full_out;
  logic [31:0] trig_num;
  logic [TS_W-1:0] trig_ts;

  int checks = 0, failures = 0;
  int ntrig = 0;
  int unsigned cyc = 0;

  fc_trig_rx u0 (.clk(clk), .rst_n(rst_n), .l1_in(l1_in), .chk_in(chk_in),
    .occ_in(occ_in), .hi_mark(hi_mark), .lo_mark(lo_mark), .trig_evt(trig_evt),
    .trig_num(trig_num), .trig_ts(trig_ts), .sync_err(sync_err),
    .malformed_err(malformed_err), .full_out(full_out));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; l1_in = 1'b0; chk_in = 1'b0; occ_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ntrig = 0;
    @(negedge clk);
  endtask

  task automatic pulse(input int len, input bit verify);
    logic [TS_W-1:0] e_ts;
    @(negedge clk);
    l1_in = 1'b1;
    e_ts = TS_W'(cyc);
    ntrig++;
    @(negedge clk);
    if (verify) begin
      check(trig_evt == 1'b1, "R2 evt", trig_evt, 1);
      check(trig_num == 32'(ntrig), "R2 num", trig_num, ntrig);
      check(trig_ts == e_ts, "R3 ts", trig_ts, e_ts);
    end
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      if (verify && i == 1) check(trig_evt == 1'b0, "R2 one cycle", trig_evt, 0);
    end
    l1_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic strobe_check();
    chk_in = 1'b1;
    @(negedge clk);
    chk_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check(trig_evt == 0 && trig_num == 0 && trig_ts == 0, "R1 trig outs", trig_num, 0);
    check(sync_err == 0 && malformed_err == 0 && full_out == 0, "R1 flags",
          {sync_err, malformed_err, full_out}, 0);
  endtask

  task automatic t_basic();
    do_reset();
    repeat (5) @(negedge clk);
    pulse(8, 1'b1);
    repeat (7) @(negedge clk);
    pulse(8, 1'b1);
    pulse(8, 1'b1);
    check(malformed_err == 0, "R4 exact length clean", malformed_err, 0);
    check(trig_num == 3, "R2 count after three", trig_num, 3);
  endtask

  task automatic t_malformed();
    do_reset();
    pulse(3, 1'b1);
    check(malformed_err == 1, "R4 short pulse", malformed_err, 1);
    check(trig_num == 1, "R4 short counted once", trig_num, 1);
    do_reset();
    pulse(12, 1'b1);
    check(malformed_err == 1, "R4 long pulse", malformed_err, 1);
    check(trig_num == 1, "R4 long counted once", trig_num, 1);
    pulse(8, 1'b0);
    check(malformed_err == 1, "R10 malformed sticky", malformed_err, 1);
  endtask

  task automatic t_sync_ok();
    do_reset();
    for (int k = 0; k < 256; k++) pulse(8, 1'b0);
    check(trig_num == 256, "R5 count 256", trig_num, 256);
    strobe_check();
    check(sync_err == 0, "R5 check on boundary", sync_err, 0);
    pulse(8, 1'b1);
    check(sync_err == 0, "R5 debt cleared", sync_err, 0);
  endtask

  task automatic t_sync_extra();
    do_reset();
    strobe_check();
    check(sync_err == 1, "R6 check at zero", sync_err, 1);
    do_reset();
    for (int k = 0; k < 5; k++) pulse(8, 1'b0);
    strobe_check();
    check(sync_err == 1, "R6 check at five", sync_err, 1);
    pulse(8, 1'b1);
    check(sync_err == 1, "R10 sync sticky", sync_err, 1);
  endtask

  task automatic t_sync_missing();
    do_reset();
    for (int k = 0; k < 256; k++) pulse(8, 1'b0);
    check(sync_err == 0, "R7 no error before next trigger", sync_err, 0);
    pulse(8, 1'b1);
    check(sync_err == 1, "R7 missing check", sync_err, 1);
    check(trig_num == 257, "R7 still counted", trig_num, 257);
  endtask

  task automatic t_full();
    do_reset();
    hi_mark = 10'd10; lo_mark = 10'd4;
    occ_in = 10'd9; @(negedge clk);
    check(full_out == 0, "R8 below high mark", full_out, 0);
    occ_in = 10'd10; @(negedge clk);
    check(full_out == 1, "R8 at high mark", full_out, 1);
    occ_in = 10'd6; @(negedge clk);
    check(full_out == 1, "R9 holds between marks", full_out, 1);
    occ_in = 10'd4; @(negedge clk);
    check(full_out == 1, "R9 holds at low mark", full_out, 1);
    occ_in = 10'd3; @(negedge clk);
    check(full_out == 0, "R9 below low mark", full_out, 0);
    occ_in = 10'd7; @(negedge clk);
    check(full_out == 0, "R9 stays low between marks", full_out, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_malformed();
    t_sync_ok();
    t_sync_extra();
    t_sync_missing();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule